// File: doc/BRIEF.md
# ADC Conversion Sequencer with Channel Injection

This block controls a successive-approximation converter core and decides which channel is converted next. There are two sources of work. Standard conversions begin when software raises a start bit. They run on one channel or as a downward scan over a channel range, and can be set to repeat. Injected conversions are one-off requests for a separately given channel. A request comes either from a hardware compare event or from a software request pulse.

The sequencer owns the arbitration between the two sources, so that no request is lost or aborted:

- A pending injection always wins the next free converter slot.
- A conversion that is already running is always allowed to finish.
- After an injection, an interrupted standard sequence picks up where it stopped.

Each request kind has its own one-cycle completion pulse and its own result register, which holds the data and the channel it came from.

The converter core sits outside the block. The core receives a start pulse with a channel number. It then returns a one-cycle done pulse with the data after a fixed number of cycles.

Top module: `adc_inject_seq`

## Requirements
- R1: After reset, `convStart`, `stdBusy`, `injBusy`, `injPending`, `stdDoneP` and `injDoneP` are 0, and both result registers and both result channel registers are 0.
- R2: A standard pass begins only on a 0-to-1 transition of `stdStartBit`. With `stdMode` = 2'b00 (single), channel `stdChan` is converted once. `stdDoneP` then pulses for one cycle, with `stdResult` = core data and `stdResultChan` = the channel.
- R3: With `stdMode[0]` = 1 (scan), one pass converts channels `stdChan`, `stdChan`-1, down to 0, in that order.
- R4: With `stdMode[1]` = 1 (continuous), a new pass starts after each pass while `stdStartBit` is still 1. Once `stdStartBit` is cleared, the current pass completes and the sequencer goes idle.
- R5: A pulse on `injHwTrig` or `injSwReq` requests one conversion of `injChan`, sampled with the request. Completion pulses `injDoneP` and loads `injResult` / `injResultChan`. The standard result registers are left unchanged.
- R6: When an injection request and a standard start edge arrive in the same cycle, the injected conversion is performed first, then the standard pass.
- R7: An injection requested during a standard sequence waits for the channel being converted to finish. The injection then runs, and the sequence resumes with the next channel.
- R8: A standard start during an injected conversion lets the injection complete. The standard pass is performed afterwards.
- R9: `injPending` is set by a request and cleared automatically when its conversion is started. A request that arrives while an injection is running is serviced afterwards.
- R10: A start edge while a standard sequence is active is ignored, and the running pass is neither restarted nor extended.
- R11: Only one conversion is started at a time. `stdDoneP` and `injDoneP` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stdStartBit | input | 1 | Standard start bit (rising edge starts, level keeps continuous mode running) |
| stdMode | input | 2 | Bit 0 scan, bit 1 continuous |
| stdChan | input | CW | Single channel, or highest channel of a scan |
| injHwTrig | input | 1 | Hardware compare event injection request |
| injSwReq | input | 1 | Software injection request pulse |
| injChan | input | CW | Channel for the injection request |
| convDone | input | 1 | Core done pulse |
| convData | input | DW | Core conversion data, valid with convDone |
| convStart | output | 1 | Start pulse to the core |
| convChan | output | CW | Channel for the core, valid with convStart |
| stdBusy | output | 1 | Standard sequence active |
| injBusy | output | 1 | Injected conversion in progress |
| injPending | output | 1 | Injection request waiting |
| stdDoneP | output | 1 | Standard conversion complete pulse |
| stdResult | output | DW | Last standard result |
| stdResultChan | output | CW | Channel of last standard result |
| injDoneP | output | 1 | Injected conversion complete pulse |
| injResult | output | DW | Last injected result |
| injResultChan | output | CW | Channel of last injected result |

## Verification
A faulty pending flag or kind register shows up within one conversion as a done pulse of the wrong kind, or as a channel out of order at the result ports. It can also show as an injection that never completes, which the drain wait exposes. A wrong scan counter or continuous restart shows as a missing, extra or misordered channel in the result stream within a pass. A busy flag that is not cleared leaves `stdBusy` or `injPending` stuck after the drain.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadStd;   // load scan counter from stdChan
    logic decStd;    // step scan counter down
    logic latchInj;  // capture injection channel
    logic startConv; // conversion launched this cycle
    logic selInj;    // launched conversion is injected
    logic capStd;    // capture standard result
    logic capInj;    // capture injected result
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stdStartBit,
  input  logic [1:0] stdMode,
  input  logic       injHwTrig,
  input  logic       injSwReq,
  input  logic       convDone,
  input  logic       stdChZero,
  output seqStrobe_t strb,
  output logic       convStart,
  output logic       stdBusy,
  output logic       injBusy,
  output logic       injPending,
  output logic       stdDoneP,
  output logic       injDoneP
);
  logic startQ, convActive, kindInj, stdActive, injPend;
  logic startEdge, injReq, pickInj, pickStd;
  logic stdFin, injFin, passEnd, restart, scanMode, contMode;

  assign scanMode  = stdMode[0];
  assign contMode  = stdMode[1];
  assign startEdge = stdStartBit & ~startQ;
  assign injReq    = injHwTrig | injSwReq;
  // injection has priority whenever the core is free
  assign pickInj   = !convActive && injPend;
  assign pickStd   = !convActive && !injPend && stdActive;
  assign convStart = pickInj | pickStd;
  assign stdFin    = convActive && !kindInj && convDone;
  assign injFin    = convActive && kindInj && convDone;
  assign passEnd   = stdFin && (!scanMode || stdChZero);
  assign restart   = passEnd && contMode && stdStartBit;

  always_comb begin
    strb           = '0;
    strb.loadStd   = (startEdge && !stdActive) || restart;
    strb.decStd    = stdFin && scanMode && !stdChZero;
    strb.latchInj  = injReq;
    strb.startConv = convStart;
    strb.selInj    = pickInj;
    strb.capStd    = stdFin;
    strb.capInj    = injFin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ     <= 1'b0;
      convActive <= 1'b0;
      kindInj    <= 1'b0;
      stdActive  <= 1'b0;
      injPend    <= 1'b0;
      stdDoneP   <= 1'b0;
      injDoneP   <= 1'b0;
    end else begin
      startQ   <= stdStartBit;
      stdDoneP <= stdFin;
      injDoneP <= injFin;
      if (convStart) begin
        convActive <= 1'b1;
        kindInj    <= pickInj;
      end else if (convDone) begin
        convActive <= 1'b0;
      end
      // a fresh request keeps pending set even when the old one is accepted
      if (injReq) injPend <= 1'b1;
      else if (pickInj) injPend <= 1'b0;
      if (startEdge && !stdActive) stdActive <= 1'b1;
      else if (passEnd && !restart) stdActive <= 1'b0;
    end
  end

  assign stdBusy    = stdActive;
  assign injBusy    = convActive && kindInj;
  assign injPending = injPend;
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int CW = 4,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strb,
  input  logic [CW-1:0] stdChan,
  input  logic [CW-1:0] injChan,
  input  logic [DW-1:0] convData,
  output logic [CW-1:0] convChan,
  output logic          stdChZero,
  output logic [DW-1:0] stdResult,
  output logic [CW-1:0] stdResultChan,
  output logic [DW-1:0] injResult,
  output logic [CW-1:0] injResultChan
);
  localparam logic [CW-1:0] CH_ZERO = '0;
  localparam logic [CW-1:0] CH_ONE  = CW'(1);

  logic [CW-1:0] stdCh, injCh, activeCh;

  assign stdChZero = (stdCh == CH_ZERO);
  assign convChan  = strb.selInj ? injCh : stdCh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stdCh         <= '0;
      injCh         <= '0;
      activeCh      <= '0;
      stdResult     <= '0;
      stdResultChan <= '0;
      injResult     <= '0;
      injResultChan <= '0;
    end else begin
      if (strb.loadStd) stdCh <= stdChan;
      else if (strb.decStd) stdCh <= stdCh - CH_ONE;
      if (strb.latchInj) injCh <= injChan;
      if (strb.startConv) activeCh <= convChan;
      if (strb.capStd) begin
        stdResult     <= convData;
        stdResultChan <= activeCh;
      end
      if (strb.capInj) begin
        injResult     <= convData;
        injResultChan <= activeCh;
      end
    end
  end
endmodule

// File: rtl/adc_inject_seq.sv
module adc_inject_seq
  import adc_seq_pkg::*;
#(
  parameter int CW = 4,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stdStartBit,
  input  logic [1:0]    stdMode,
  input  logic [CW-1:0] stdChan,
  input  logic          injHwTrig,
  input  logic          injSwReq,
  input  logic [CW-1:0] injChan,
  input  logic          convDone,
  input  logic [DW-1:0] convData,
  output logic          convStart,
  output logic [CW-1:0] convChan,
  output logic          stdBusy,
  output logic          injBusy,
  output logic          injPending,
  output logic          stdDoneP,
  output logic [DW-1:0] stdResult,
  output logic [CW-1:0] stdResultChan,
  output logic          injDoneP,
  output logic [DW-1:0] injResult,
  output logic [CW-1:0] injResultChan
);
  seqStrobe_t strb;
  logic       stdChZero;

  adc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stdStartBit(stdStartBit), .stdMode(stdMode),
    .injHwTrig(injHwTrig), .injSwReq(injSwReq), .convDone(convDone),
    .stdChZero(stdChZero), .strb(strb), .convStart(convStart),
    .stdBusy(stdBusy), .injBusy(injBusy), .injPending(injPending),
    .stdDoneP(stdDoneP), .injDoneP(injDoneP)
  );

  adc_seq_dp #(.CW(CW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stdChan(stdChan), .injChan(injChan),
    .convData(convData), .convChan(convChan), .stdChZero(stdChZero),
    .stdResult(stdResult), .stdResultChan(stdResultChan),
    .injResult(injResult), .injResultChan(injResultChan)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rstN,
  input logic injHwTrig,
  input logic injSwReq,
  input logic convStart,
  input logic injPending,
  input logic injBusy,
  input logic stdBusy,
  input logic stdDoneP,
  input logic injDoneP
);
  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !(stdDoneP && injDoneP)); // R11

  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R11

  AST_INJ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && injPending) |=> injBusy); // R6

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && injPending && !injHwTrig && !injSwReq) |=> !injPending); // R9

  AST_INJ_DONE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    injDoneP |-> $past(injBusy)); // R5

  AST_STD_DONE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    stdDoneP |-> $past(stdBusy)); // R2
endmodule

bind adc_inject_seq adc_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .injHwTrig(injHwTrig), .injSwReq(injSwReq),
  .convStart(convStart), .injPending(injPending), .injBusy(injBusy),
  .stdBusy(stdBusy), .stdDoneP(stdDoneP), .injDoneP(injDoneP)
);

// File: tb/sim_adc_inject_seq.sv
`timescale 1ns/1ps
module sim_adc_inject_seq;
  localparam int CW  = 4;
  localparam int DW  = 10;
  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stdStartBit = 1'b0;
  logic [1:0] stdMode = 2'b00;
  logic [CW-1:0] stdChan = '0;
  logic injHwTrig = 1'b0;
  logic injSwReq = 1'b0;
  logic [CW-1:0] injChan = '0;
  logic convDone = 1'b0;
  logic [DW-1:0] convData = '0;
  logic convStart, stdBusy, injBusy, injPending, stdDoneP, injDoneP;
  logic [CW-1:0] convChan, stdResultChan, injResultChan;
  logic [DW-1:0] stdResult, injResult;

  always #2 clk = ~clk;

  adc_inject_seq #(.CW(CW), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .stdStartBit(stdStartBit), .stdMode(stdMode),
    .stdChan(stdChan), .injHwTrig(injHwTrig), .injSwReq(injSwReq),
    .injChan(injChan), .convDone(convDone), .convData(convData),
    .convStart(convStart), .convChan(convChan), .stdBusy(stdBusy),
    .injBusy(injBusy), .injPending(injPending), .stdDoneP(stdDoneP),
    .stdResult(stdResult), .stdResultChan(stdResultChan), .injDoneP(injDoneP),
    .injResult(injResult), .injResultChan(injResultChan)
  );

  int checks = 0;
  int fails  = 0;
  int stdDoneCnt = 0;

  function automatic logic [DW-1:0] expData(input logic [CW-1:0] ch);
    return DW'(ch) * DW'(37) + DW'(5);
  endfunction

  // converter core model with fixed latency
  int coreCnt = 0;
  logic [CW-1:0] coreCh = '0;
  always @(posedge clk) begin
    convDone <= 1'b0;
    if (!rstN) coreCnt <= 0;
    else if (convStart) begin
      coreCnt <= LAT;
      coreCh  <= convChan;
    end else if (coreCnt == 1) begin
      convDone <= 1'b1;
      convData <= expData(coreCh);
      coreCnt  <= 0;
    end else if (coreCnt > 1) coreCnt <= coreCnt - 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard: {kind(1=inj), channel}
  logic [CW:0] sbq[$];
  string curReq = "R2";

  task automatic push(input bit inj, input int ch);
    sbq.push_back({inj, CW'(ch)});
  endtask

  always @(negedge clk) begin
    if (rstN && (stdDoneP || injDoneP)) begin
      if (stdDoneP) stdDoneCnt++;
      if (sbq.size() == 0) begin
        chk(1'b0, {curReq, " unexpected done"}, 1, 0);
      end else begin
        logic [CW:0] it;
        logic [CW-1:0] gotCh;
        logic [DW-1:0] gotD;
        it = sbq.pop_front();
        gotCh = injDoneP ? injResultChan : stdResultChan;
        gotD  = injDoneP ? injResult : stdResult;
        chk(injDoneP == it[CW], {curReq, " kind"}, int'(injDoneP), int'(it[CW]));
        chk(gotCh == it[CW-1:0], {curReq, " channel"}, int'(gotCh), int'(it[CW-1:0]));
        chk(gotD == expData(it[CW-1:0]), {curReq, " data"}, int'(gotD), int'(expData(it[CW-1:0])));
      end
    end
  end

  task automatic drain();
    while (sbq.size() != 0 || stdBusy || injBusy || injPending) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic injPulse(input bit hw, input int ch);
    injChan = CW'(ch);
    if (hw) injHwTrig = 1'b1; else injSwReq = 1'b1;
    @(negedge clk);
    injHwTrig = 1'b0;
    injSwReq  = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!convStart && !stdBusy && !injBusy && !injPending, "R1 control flags", 1, 0);
    chk(!stdDoneP && !injDoneP, "R1 done pulses", int'(stdDoneP | injDoneP), 0);
    chk(stdResult == 0 && injResult == 0 && stdResultChan == 0 && injResultChan == 0,
        "R1 results", int'(stdResult), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 single conversion
    curReq = "R2";
    push(0, 5);
    stdMode = 2'b00; stdChan = 4'd5; stdStartBit = 1'b1;
    @(negedge clk);
    chk(stdBusy, "R2 busy after edge", int'(stdBusy), 1);
    drain();
    chk(!stdBusy, "R2 idle after single", int'(stdBusy), 0);
    stdStartBit = 1'b0;
    repeat (2) @(negedge clk);

    // R3 scan
    curReq = "R3";
    push(0, 3); push(0, 2); push(0, 1); push(0, 0);
    stdMode = 2'b01; stdChan = 4'd3; stdStartBit = 1'b1;
    drain();
    stdStartBit = 1'b0;
    @(negedge clk);

    // R5 / R9 hardware injection while idle
    curReq = "R5";
    push(1, 7);
    injPulse(1, 7);
    chk(injPending, "R9 pending set", int'(injPending), 1);
    @(negedge clk);
    chk(!injPending && injBusy, "R9 pending cleared on accept", int'(injPending), 0);
    drain();
    chk(stdResultChan == 4'd0, "R5 std result untouched", int'(stdResultChan), 0);

    // R6 collision: software injection and start edge in the same cycle
    curReq = "R6";
    push(1, 9); push(0, 2); push(0, 1); push(0, 0);
    stdMode = 2'b01; stdChan = 4'd2; injChan = 4'd9;
    stdStartBit = 1'b1; injSwReq = 1'b1;
    @(negedge clk);
    injSwReq = 1'b0;
    drain();
    stdStartBit = 1'b0;
    @(negedge clk);

    // R7 injection in the middle of a scan
    curReq = "R7";
    push(0, 3); push(1, 12); push(0, 2); push(0, 1); push(0, 0);
    stdMode = 2'b01; stdChan = 4'd3; stdStartBit = 1'b1;
    repeat (3) @(negedge clk);
    injPulse(1, 12);
    drain();
    stdStartBit = 1'b0;
    @(negedge clk);

    // R8 standard start during injection
    curReq = "R8";
    push(1, 4); push(0, 6);
    injPulse(0, 4);
    @(negedge clk);
    stdMode = 2'b00; stdChan = 4'd6; stdStartBit = 1'b1;
    drain();
    stdStartBit = 1'b0;
    @(negedge clk);

    // R9 request during running injection is served afterwards
    curReq = "R9";
    push(1, 1); push(1, 3);
    injPulse(1, 1);
    repeat (3) @(negedge clk);
    chk(injBusy, "R9 first injection running", int'(injBusy), 1);
    injPulse(0, 3);
    drain();

    // R10 second edge while scanning is ignored
    curReq = "R10";
    push(0, 3); push(0, 2); push(0, 1); push(0, 0);
    stdMode = 2'b01; stdChan = 4'd3; stdStartBit = 1'b1;
    repeat (2) @(negedge clk);
    stdStartBit = 1'b0;
    @(negedge clk);
    stdStartBit = 1'b1;
    drain();
    chk(!stdBusy, "R10 no extra pass", int'(stdBusy), 0);
    stdStartBit = 1'b0;
    @(negedge clk);

    // R4 continuous single: clear after third done, one more completes
    curReq = "R4";
    push(0, 2); push(0, 2); push(0, 2); push(0, 2);
    stdDoneCnt = 0;
    stdMode = 2'b10; stdChan = 4'd2; stdStartBit = 1'b1;
    while (stdDoneCnt < 3) @(negedge clk);
    stdStartBit = 1'b0;
    drain();
    chk(stdDoneCnt == 4, "R4 continuous single count", stdDoneCnt, 4);

    // R4 continuous scan: clear after first pass, second pass completes
    push(0, 1); push(0, 0); push(0, 1); push(0, 0);
    stdDoneCnt = 0;
    stdMode = 2'b11; stdChan = 4'd1; stdStartBit = 1'b1;
    while (stdDoneCnt < 2) @(negedge clk);
    stdStartBit = 1'b0;
    drain();
    chk(stdDoneCnt == 4, "R4 continuous scan count", stdDoneCnt, 4);
    chk(!stdBusy && !injBusy, "R11 idle at end", int'(stdBusy), 0);

    summary();
    $finish;
  end
endmodule